// File: doc/BRIEF.md
# Register-Driven Two-Wire Byte Access Master

This block is a two-wire serial bus master that moves one byte per request. A host sets it up through four byte-wide registers: a word index, a target address, a data byte and a control/status byte. The transfer starts when the host writes the target address register. Bit 0 of that address selects the direction, where 1 means read. A framing bit in the control byte chooses between two forms. The long form places the index byte after the address, and a read in this form continues with a repeated START and a second address phase. The short form sends only the address and then moves a single data byte.

While a transfer runs, the block sets a busy flag. It clears the flag only after it has driven the STOP condition. For a read, the received byte is already in the data register when busy drops. If the target does not acknowledge an address or data byte, the block raises a sticky error flag, ends the access with a STOP and releases busy. The clock line is timed from the system clock by a quarter-period divider. A test bit makes that divider eight times shorter. Two further status bits mirror an external configuration loader. Both bus lines are open-drain, and each is brought out as a pull-low enable.

Top module: `smb_byte_master`

## Requirements
- R1: After reset, all four registers read 00h and neither bus line is pulled low. Register select 0 is the index, 1 the target address, 2 the data byte and 3 the control/status byte.
- R2: Control/status layout: bit 7 is the framing select, bit 6 always reads 0, bit 5 is busy, bit 4 is loader busy, bit 3 is bus enable, bit 2 is fast test, bit 1 is request error and bit 0 is loader error. A host write stores bits 7, 3 and 2 as written. The write has no effect on bits 6, 5 and 4.
- R3: A write to the target address register while bus enable is 1 and busy is 0 sets busy in the next cycle and starts the transfer with a START.
- R4: With framing select 0, a write sends the address with bit 0 cleared, then the index, then the data byte. A read sends the address with bit 0 cleared, then the index, then a repeated START, then the address with bit 0 set, and then receives one byte.
- R5: With framing select 1, a write sends the address followed by the data byte, and a read sends the address with bit 0 set and then receives one byte. No index byte appears on the bus.
- R6: Busy stays 1 until the STOP has been driven. After a successful read, the master leaves the bit after the received byte unacknowledged (line high), and the data register holds the received byte when busy clears.
- R7: A byte with no acknowledge from the target sets bit 1, ends the access with a STOP and clears busy, and leaves the data register unchanged. Bit 1 stays 1 until the host writes 1 to it; writing 0 to it has no effect.
- R8: While bus enable is 0, a write to the target address starts nothing. While busy is 1, writes to the index, target address and data registers are ignored.
- R9: One clock-line period lasts 4*QTR_NORM system cycles, or 4*(QTR_NORM>>3) with the fast test bit set. A transfer of n bytes with one START and one STOP holds busy for (8+36*n) quarter periods.
- R10: Bit 4 follows the loader-busy input. A loader-error pulse sets bit 0, which stays set until the host writes 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 index, 1 target address, 2 data, 3 control/status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| loader_busy | input | 1 | Loader activity, mirrored in status bit 4 |
| loader_err | input | 1 | Loader error pulse, sets status bit 0 |
| scl_oe | output | 1 | Pull the clock line low when 1 |
| sda_oe | output | 1 | Pull the data line low when 1 |
| sda_in | input | 1 | Sampled level of the data line |

## Verification
The hardest cases to reach from the ports are the two abort paths: a missing acknowledge on the index byte, and one on the second address phase after a repeated START. Both depend on the target's reply in the middle of a frame. The bench includes a behavioural bus target that decodes START and STOP, logs every byte it receives and answers or withholds each acknowledge by byte position. Each table row can therefore pick the exact byte that goes unacknowledged. The same target observes the master's final unacknowledged bit on reads, and a write to the address register in the cycle after a launch shows that a live transfer cannot be disturbed.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam logic [1:0] RA_INDEX = 2'd0;
  localparam logic [1:0] RA_TADDR = 2'd1;
  localparam logic [1:0] RA_DATA  = 2'd2;
  localparam logic [1:0] RA_CTRL  = 2'd3;

  typedef enum logic [2:0] {
    SK_START, SK_TXAW, SK_TXAR, SK_TXIDX, SK_TXDAT, SK_RX, SK_RSTART, SK_STOP
  } slot_kind_t;

  // Frame plan: which step comes at position 'slot' for a given direction and framing
  function automatic slot_kind_t slot_kind(input logic [2:0] slot, input logic rd,
                                           input logic short_form);
    slot_kind_t k;
    k = SK_STOP;
    unique case ({rd, short_form})
      2'b00: case (slot)
               3'd0: k = SK_START;  3'd1: k = SK_TXAW;
               3'd2: k = SK_TXIDX;  3'd3: k = SK_TXDAT;
               default: k = SK_STOP;
             endcase
      2'b01: case (slot)
               3'd0: k = SK_START;  3'd1: k = SK_TXAW;
               3'd2: k = SK_TXDAT;
               default: k = SK_STOP;
             endcase
      2'b10: case (slot)
               3'd0: k = SK_START;  3'd1: k = SK_TXAW;
               3'd2: k = SK_TXIDX;  3'd3: k = SK_RSTART;
               3'd4: k = SK_TXAR;   3'd5: k = SK_RX;
               default: k = SK_STOP;
             endcase
      default: case (slot)
               3'd0: k = SK_START;  3'd1: k = SK_TXAR;
               3'd2: k = SK_RX;
               default: k = SK_STOP;
             endcase
    endcase
    return k;
  endfunction

  function automatic logic is_byte(input slot_kind_t k);
    return (k == SK_TXAW) || (k == SK_TXAR) || (k == SK_TXIDX) ||
           (k == SK_TXDAT) || (k == SK_RX);
  endfunction

  function automatic logic [7:0] tx_byte(input slot_kind_t k, input logic [7:0] taddr,
                                         input logic [7:0] idx, input logic [7:0] wd);
    logic [7:0] b;
    case (k)
      SK_TXAW:  b = {taddr[7:1], 1'b0};
      SK_TXAR:  b = {taddr[7:1], 1'b1};
      SK_TXIDX: b = idx;
      default:  b = wd;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/smb_qdiv.sv
module smb_qdiv #(
  parameter int QTR_NORM   = 500,
  parameter int TEST_SHIFT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int QTR_TEST = ((QTR_NORM >> TEST_SHIFT) < 1) ? 1 : (QTR_NORM >> TEST_SHIFT);
  localparam int CW       = $clog2(QTR_NORM + 1);
  localparam logic [CW-1:0] LIM_N = CW'(QTR_NORM - 1);
  localparam logic [CW-1:0] LIM_T = CW'(QTR_TEST - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? LIM_T : LIM_N;
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       loader_busy,
  input  logic       loader_err,
  input  logic       xfer_done,
  input  logic       nack_evt,
  input  logic       rx_load,
  input  logic [7:0] rx_byte,
  output logic [7:0] idx_q,
  output logic [7:0] taddr_q,
  output logic [7:0] data_q,
  output logic       short_form,
  output logic       fast_test,
  output logic       det_en,
  output logic       busy,
  output logic       req_err,
  output logic       sa_wr,
  output logic       err_clr,
  output logic       start_req
);
  logic ld_err;
  logic ctrl_wr;

  assign ctrl_wr   = reg_wr && (reg_addr == RA_CTRL);
  assign sa_wr     = reg_wr && (reg_addr == RA_TADDR);
  assign err_clr   = ctrl_wr && reg_wdata[1];
  assign start_req = sa_wr && det_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0; taddr_q <= '0; data_q <= '0;
      short_form <= 1'b0; fast_test <= 1'b0; det_en <= 1'b0;
      busy <= 1'b0; req_err <= 1'b0; ld_err <= 1'b0;
    end else begin
      if (reg_wr && !busy && reg_addr == RA_INDEX) idx_q <= reg_wdata;
      if (start_req) taddr_q <= reg_wdata;
      if (rx_load)                                       data_q <= rx_byte;
      else if (reg_wr && !busy && reg_addr == RA_DATA)   data_q <= reg_wdata;
      if (ctrl_wr) begin
        short_form <= reg_wdata[7];
        det_en     <= reg_wdata[3];
        fast_test  <= reg_wdata[2];
      end
      if (start_req)      busy <= 1'b1;
      else if (xfer_done) busy <= 1'b0;
      if (nack_evt)       req_err <= 1'b1;
      else if (err_clr)   req_err <= 1'b0;
      if (loader_err)                     ld_err <= 1'b1;
      else if (ctrl_wr && reg_wdata[0])   ld_err <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_INDEX: reg_rdata = idx_q;
      RA_TADDR: reg_rdata = taddr_q;
      RA_DATA:  reg_rdata = data_q;
      default:  reg_rdata = {short_form, 1'b0, busy, loader_busy, det_en, fast_test,
                             req_err, ld_err};
    endcase
  end
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  input  logic       short_form,
  input  logic [7:0] taddr,
  input  logic [7:0] idx,
  input  logic [7:0] wd,
  input  logic       sda_in,
  output logic       active,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       done,
  output logic       nack_evt,
  output logic       rx_load,
  output logic [7:0] rx_byte
);
  logic [2:0] slot;
  logic [1:0] q;
  logic [3:0] bitn;
  logic       abort_q, sf_q, nack_seen;
  slot_kind_t kind;
  logic       byte_slot;
  logic [7:0] txb;
  logic       want_scl, want_sda, hold_sda;

  assign kind      = abort_q ? SK_STOP : slot_kind(slot, taddr[0], sf_q);
  assign byte_slot = is_byte(kind);
  assign txb       = tx_byte(kind, taddr, idx, wd);
  assign hold_sda  = (q == 2'd0) && (kind != SK_START);

  always_comb begin
    case (kind)
      SK_START:  begin want_scl = 1'b0;     want_sda = q[1];          end
      SK_RSTART: begin want_scl = !q[1];    want_sda = (q == 2'd3);   end
      SK_STOP:   begin want_scl = !q[1];    want_sda = (q != 2'd3);   end
      SK_RX:     begin want_scl = !q[1];    want_sda = 1'b0;          end
      default: begin
        want_scl = !q[1];
        want_sda = (bitn < 4'd8) ? !txb[3'd7 - bitn[2:0]] : 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; slot <= '0; q <= '0; bitn <= '0;
      abort_q <= 1'b0; sf_q <= 1'b0; nack_seen <= 1'b0;
      done <= 1'b0; nack_evt <= 1'b0; rx_load <= 1'b0; rx_byte <= '0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      done <= 1'b0; nack_evt <= 1'b0; rx_load <= 1'b0;
      if (!active) begin
        scl_oe <= 1'b0; sda_oe <= 1'b0;
        if (start) begin
          active <= 1'b1; slot <= '0; q <= '0; bitn <= '0;
          abort_q <= 1'b0; sf_q <= short_form;
        end
      end else begin
        scl_oe <= want_scl;
        if (!hold_sda) sda_oe <= want_sda;
        if (tick) begin
          q <= q + 2'd1;
          if (byte_slot && q == 2'd2) begin
            if (bitn < 4'd8) rx_byte <= {rx_byte[6:0], sda_in};
            else             nack_seen <= sda_in;
          end
          if (q == 2'd3) begin
            if (byte_slot && bitn != 4'd8) begin
              bitn <= bitn + 4'd1;
            end else begin
              bitn <= '0;
              if (kind == SK_STOP) begin
                active <= 1'b0; done <= 1'b1; abort_q <= 1'b0;
              end else if (byte_slot && kind != SK_RX && nack_seen) begin
                abort_q <= 1'b1; nack_evt <= 1'b1;
              end else begin
                slot <= slot + 3'd1;
                if (kind == SK_RX) rx_load <= 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/smb_byte_master.sv
module smb_byte_master #(
  parameter int QTR_NORM   = 500,
  parameter int TEST_SHIFT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       loader_busy,
  input  logic       loader_err,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic [7:0] idx_q, taddr_q, data_q, rx_byte;
  logic short_form, fast_test, det_en, busy, req_err, sa_wr, err_clr, start_req;
  logic xfer_done, nack_evt, rx_load, active, qtick;

  smb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .loader_busy(loader_busy),
    .loader_err(loader_err), .xfer_done(xfer_done), .nack_evt(nack_evt),
    .rx_load(rx_load), .rx_byte(rx_byte), .idx_q(idx_q), .taddr_q(taddr_q),
    .data_q(data_q), .short_form(short_form), .fast_test(fast_test),
    .det_en(det_en), .busy(busy), .req_err(req_err), .sa_wr(sa_wr),
    .err_clr(err_clr), .start_req(start_req)
  );

  smb_qdiv #(.QTR_NORM(QTR_NORM), .TEST_SHIFT(TEST_SHIFT)) u_div (
    .clk(clk), .rst_n(rst_n), .run(active), .fast(fast_test), .tick(qtick)
  );

  smb_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_req), .tick(qtick),
    .short_form(short_form), .taddr(taddr_q), .idx(idx_q), .wd(data_q),
    .sda_in(sda_in), .active(active), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(xfer_done), .nack_evt(nack_evt), .rx_load(rx_load), .rx_byte(rx_byte)
  );
endmodule

module smb_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_req,
  input logic       xfer_done,
  input logic       nack_evt,
  input logic       rx_load,
  input logic       busy,
  input logic       req_err,
  input logic       det_en,
  input logic       sa_wr,
  input logic       err_clr,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));                                  // R1
  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> !reg_rdata[6]);                            // R2
  AST_BUSY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> busy);                                              // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> busy);                                   // R6
  AST_RX_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |-> busy);                                                // R6
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> req_err);                                            // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_err && !err_clr) |=> req_err);                               // R7
  AST_NODET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_wr && !det_en && !busy) |=> !busy);                           // R8
endmodule

bind smb_byte_master smb_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .xfer_done(xfer_done),
  .nack_evt(nack_evt), .rx_load(rx_load), .busy(busy), .req_err(req_err),
  .det_en(det_en), .sa_wr(sa_wr), .err_clr(err_clr), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/smb_byte_master_tb_top.sv
`timescale 1ns/1ps
module smb_byte_master_tb_top;
  localparam int QN = 16;
  localparam int QT = QN >> 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic loader_busy = 1'b0;
  logic loader_err = 1'b0;
  logic scl_oe, sda_oe, sda_in;
  logic slv_drv = 1'b0;

  always #2.5 clk = ~clk;

  smb_byte_master #(.QTR_NORM(QN), .TEST_SHIFT(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .loader_busy(loader_busy),
    .loader_err(loader_err), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_drv);
  assign sda_in = sda_line;

  // ---------------- behavioural bus target ----------------
  int bitc, nbytes, nstarts, nstops, nack_idx;
  bit tx_mode, pend_rd, first, m_nack;
  logic [7:0] shreg, slv_tx;
  logic [7:0] log_b [8];

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    nstarts++; bitc = 0; tx_mode = 0; pend_rd = 0; first = 1;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) nstops++;
  always @(posedge scl_line) begin
    if (bitc < 8) begin
      if (!tx_mode) shreg = {shreg[6:0], sda_line};
      bitc++;
      if (bitc == 8 && !tx_mode) begin
        if (nbytes < 8) log_b[nbytes] = shreg;
        nbytes++;
        pend_rd = first && shreg[0];
        first = 0;
      end
    end else begin
      if (tx_mode) m_nack = sda_line;
      bitc = 0; tx_mode = pend_rd; pend_rd = 0;
    end
  end
  always @(negedge scl_line) begin
    if (bitc == 8)      slv_drv = !tx_mode && ((nbytes - 1) != nack_idx);
    else if (tx_mode)   slv_drv = !slv_tx[7 - bitc];
    else                slv_drv = 1'b0;
  end

  // ---------------- bookkeeping ----------------
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] s;
    n = 0;
    forever begin
      rd_reg(2'd3, s);
      if (!s[5] || n > 20000) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic reset_slave(input int nk, input logic [7:0] tx);
    bitc = 0; nbytes = 0; nstarts = 0; nstops = 0; tx_mode = 0; pend_rd = 0;
    first = 1; m_nack = 0; nack_idx = nk; slv_tx = tx;
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic       rd;
    logic       sf;
    logic [7:0] ta;
    logic [7:0] idx;
    logic [7:0] wd;
    logic [7:0] rxv;
    logic [3:0] nk;   // byte position left unacknowledged, 15 = none
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'hA0, 8'h12, 8'h5A, 8'h00, 4'd15},
    '{1'b0, 1'b1, 8'h3C, 8'h00, 8'hC3, 8'h00, 4'd15},
    '{1'b1, 1'b0, 8'hA1, 8'h34, 8'h00, 8'h96, 4'd15},
    '{1'b1, 1'b1, 8'h51, 8'h00, 8'h00, 8'h6B, 4'd15},
    '{1'b0, 1'b0, 8'hA0, 8'h12, 8'h77, 8'h00, 4'd0},
    '{1'b0, 1'b0, 8'hA0, 8'h12, 8'h88, 8'h00, 4'd1},
    '{1'b1, 1'b0, 8'hA1, 8'h34, 8'h00, 8'hE7, 4'd2},
    '{1'b1, 1'b1, 8'hC9, 8'h00, 8'h00, 8'h00, 4'd15}
  };

  function automatic int full_count(input vec_t v);
    if (!v.rd) return v.sf ? 2 : 3;
    return v.sf ? 1 : 3;
  endfunction

  function automatic logic [7:0] exp_byte(input vec_t v, input int k);
    logic [7:0] aw, ar;
    aw = {v.ta[7:1], 1'b0}; ar = {v.ta[7:1], 1'b1};
    if (v.rd && v.sf) return ar;
    if (k == 0) return aw;
    if (v.sf) return v.wd;
    if (k == 1) return v.idx;
    return v.rd ? ar : v.wd;
  endfunction

  logic [7:0] exp_data = 8'h00;

  task automatic run_vec(input vec_t v, input int vi);
    int n, cnt, nk;
    bit err;
    logic [7:0] s, d;
    string tag;
    tag = v.sf ? "R5" : "R4";
    nk = (v.nk == 4'd15) ? 99 : int'(v.nk);
    cnt = full_count(v);
    err = (nk < cnt);
    if (err) cnt = nk + 1;
    reset_slave(nk, v.rxv);
    wr_reg(2'd3, {v.sf, 7'b0001010});
    if (!v.rd) begin wr_reg(2'd2, v.wd); exp_data = v.wd; end
    wr_reg(2'd0, v.idx);
    wr_reg(2'd1, v.ta);
    rd_reg(2'd3, s);
    chk($sformatf("R3 busy after launch v%0d", vi), s[5], 1);
    wait_idle(n);
    chk($sformatf("%s byte count v%0d", tag, vi), nbytes, cnt);
    for (int k = 0; k < cnt; k++)
      chk($sformatf("%s byte %0d v%0d", tag, k, vi), log_b[k], exp_byte(v, k));
    chk($sformatf("R6 stop seen v%0d", vi), (nstops > 0), 1);
    rd_reg(2'd3, s);
    chk($sformatf("R7 error flag v%0d", vi), s[1], err);
    if (v.rd && !err) begin
      exp_data = v.rxv;
      chk($sformatf("R6 master nack v%0d", vi), m_nack, 1);
    end
    rd_reg(2'd2, d);
    chk($sformatf("R6 data reg v%0d", vi), d, exp_data);
  endtask

  initial begin
    logic [7:0] s, d;
    int n;
    reset_slave(99, 8'h00);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), d, 0);
    end
    chk("R1 scl released", scl_oe, 0);
    chk("R1 sda released", sda_oe, 0);

    // R2: control write mask
    wr_reg(2'd3, 8'hFF);
    rd_reg(2'd3, s);
    chk("R2 ctrl after FFh", s, 8'h8C);
    wr_reg(2'd3, 8'h00);
    rd_reg(2'd3, s);
    chk("R2 ctrl after 00h", s, 8'h00);
    wr_reg(2'd0, 8'h77);
    rd_reg(2'd0, d);
    chk("R2 index readback", d, 8'h77);

    // R8: bus enable off, no transfer
    reset_slave(99, 8'h00);
    wr_reg(2'd1, 8'hA0);
    repeat (3 * QN) begin
      @(negedge clk);
      if (scl_oe) n = 1;
    end
    rd_reg(2'd3, s);
    chk("R8 no busy while disabled", s[5], 0);
    chk("R8 no START while disabled", nstarts, 0);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R7: sticky error, write 0 keeps, write 1 clears
    run_vec(VECS[4], 100);
    wr_reg(2'd3, 8'h08);
    rd_reg(2'd3, s);
    chk("R7 error kept after writing 0", s[1], 1);
    wr_reg(2'd3, 8'h0A);
    rd_reg(2'd3, s);
    chk("R7 error cleared after writing 1", s[1], 0);

    // R8: writes during busy ignored
    reset_slave(99, 8'h00);
    wr_reg(2'd3, 8'h88);
    wr_reg(2'd2, 8'h11);
    wr_reg(2'd1, 8'h3C);
    wr_reg(2'd1, 8'h7E);
    wr_reg(2'd2, 8'h99);
    wait_idle(n);
    chk("R8 bytes during busy writes", nbytes, 2);
    chk("R8 address on bus", log_b[0], 8'h3C);
    chk("R8 data on bus", log_b[1], 8'h11);
    rd_reg(2'd1, d);
    chk("R8 address reg kept", d, 8'h3C);
    rd_reg(2'd2, d);
    chk("R8 data reg kept", d, 8'h11);

    // R9: busy duration in normal and fast test mode (2 bytes)
    reset_slave(99, 8'h00);
    wr_reg(2'd3, 8'h88);
    wr_reg(2'd1, 8'h3C);
    wait_idle(n);
    chk("R9 normal duration in range", (n >= 80*QN-2 && n <= 80*QN+2), 1);
    reset_slave(99, 8'h00);
    wr_reg(2'd3, 8'h8C);
    wr_reg(2'd1, 8'h3C);
    wait_idle(n);
    chk("R9 fast duration in range", (n >= 80*QT-2 && n <= 80*QT+2), 1);

    // R10: loader status
    @(negedge clk); loader_busy = 1'b1;
    rd_reg(2'd3, s);
    chk("R10 loader busy shown", s[4], 1);
    @(negedge clk); loader_busy = 1'b0; loader_err = 1'b1;
    @(negedge clk); loader_err = 1'b0;
    repeat (2) @(negedge clk);
    rd_reg(2'd3, s);
    chk("R10 loader error sticky", s[0], 1);
    chk("R10 loader busy released", s[4], 0);
    wr_reg(2'd3, 8'h09);
    rd_reg(2'd3, s);
    chk("R10 loader error cleared", s[0], 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule